// File: doc/BRIEF.md
# Multi-Lane Direct Digital Synthesizer with Sync Gating

This block is a sine-wave generator for a digital-to-analog converter whose sample clock runs CLK_RATIO times faster than the core clock. On every core clock cycle it delivers CLK_RATIO signed samples side by side. Each sample belongs to one DAC sample period, and sample 0 is the earliest in time. A phase-increment word sets the tone frequency. Each lane's phase sits one increment ahead of the lane below it, so the whole vector is one continuous stretch of the waveform.

A sync input restarts the generator coherently. While sync is high, every sample is zero and the valid flag is low. When sync is released, the phase accumulator is loaded with the initial-phase input. The output then stays at zero for a fixed settling window before the first real samples appear. A short sync pulse therefore produces exactly the same restart as a long one. Reset behaves like a sync pulse that ends when reset is released.

Top module: `multilane_dds`

## Requirements
- R1: Every core cycle, samples_o carries CLK_RATIO 16-bit two's-complement samples. Lane k occupies bits [16k+15:16k], and lane 0 is the earliest in time. For a lane phase ph, the sample is round(32767 * sin(2*pi*(p+0.5)/256)), where p = ph[15:8]. Rounding is half away from zero.
- R2: Within one valid cycle, lane k uses phase base + k*inc (mod 2^16), where inc is the current phase-increment input.
- R3: At a clock edge where sync_i is sampled high, the registered outputs become all-zero samples with valid_o low. Whenever valid_o is low, samples_o is all zero.
- R4: At the first edge where sync_i is sampled low after being high (or after reset), the base phase is loaded from init_phase_i. The first valid cycle then shows lane 0 at exactly that phase.
- R5: valid_o first rises on the output registered at the (CLK_RATIO+2)-th consecutive edge with sync_i low. Before that, the output stays zero, so the window after release is at least CLK_RATIO+1 cycles.
- R6: A one-cycle sync pulse, or a sync re-asserted inside the settling window, gives the same restart timing and phases as a long pulse.
- R7: After each valid cycle the base phase advances by CLK_RATIO*inc, modulo 2^16.
- R8: A change of phase_inc_i while running takes effect in the next output cycle and does not reset the accumulated phase.
- R9: While rst_n is low, samples_o is zero and valid_o is low. After reset the block behaves as if sync had just been released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_i | input | 1 | Holds the generator idle; its release restarts all lanes |
| phase_inc_i | input | 16 | Phase step per DAC sample period |
| init_phase_i | input | 16 | Phase loaded on sync release |
| samples_o | output | CLK_RATIO*16 | Packed samples, lane 0 in the low bits |
| valid_o | output | 1 | High when samples_o carries real samples |

## Verification
The hardest situations to reach are a sync pulse shorter than the settling window and a sync re-asserted partway through that window. Both can leave lanes misaligned if the window is not restarted. The stimulus drives a single-cycle pulse, then a release followed by a re-assertion two cycles into the settling window. Each time, the reference model must see the first valid vector on the exact cycle and at the exact initial phase. A large increment forces the accumulator to wrap, and per-cycle increment changes test that the phase carries over without a reset.

// File: rtl/mldds_pkg.sv
// Package for the multi-lane DDS.
// Holds the constant function that builds the quarter-wave amplitude table.
// Assumes the table is sampled at half-step offsets, so the quadrant mirror is exact.
package mldds_pkg;

    localparam real PI_R = 3.14159265358979323846;

    // Amplitude of quarter-wave entry i, for a table of 2**aw entries and sw-bit signed output.
    function automatic int quarter_amp(input int i, input int aw, input int sw);
        real ang;
        real val;
        ang = (real'(i) + 0.5) * PI_R / (2.0 * real'(1 << aw));
        val = real'((1 << (sw - 1)) - 1) * $sin(ang);
        return $rtoi(val + 0.5);
    endfunction

endpackage

// File: rtl/mldds_sync_ctrl.sv
// Sync sequencer for the multi-lane DDS.
// Detects the release of sync (or the end of reset), asks for an accumulator load,
// and holds the generator idle for RATIO further cycles before running.
// Assumes sync_i is synchronous to clk.
module mldds_sync_ctrl #(
    parameter int RATIO = 4,
    parameter int CNT_W = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_i,
    output logic load_o,
    output logic run_o
);

    localparam logic [CNT_W-1:0] SETTLE = CNT_W'(RATIO);

    logic             held_q;
    logic [CNT_W-1:0] wait_q;

    // Track the previous sync level and count down the settling window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= 1'b1;
            wait_q <= SETTLE;
        end else if (sync_i) begin
            held_q <= 1'b1;
            wait_q <= SETTLE;
        end else if (held_q) begin
            held_q <= 1'b0;
            wait_q <= SETTLE;
        end else if (wait_q != '0) begin
            wait_q <= wait_q - 1'b1;
        end
    end

    // The load happens on the release edge; running starts once the window has elapsed.
    always_comb begin
        load_o = held_q && !sync_i;
        run_o  = !held_q && !sync_i && (wait_q == '0);
    end

endmodule

// File: rtl/mldds_phase_acc.sv
// Phase accumulator for the multi-lane DDS.
// Keeps the base phase of lane 0 and derives every lane's phase as base + k*inc.
// Loads the initial phase on request and advances by LANES*inc on each running cycle.
module mldds_phase_acc #(
    parameter int LANES   = 4,
    parameter int PHASE_W = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            load_i,
    input  logic                            run_i,
    input  logic [PHASE_W-1:0]              init_phase_i,
    input  logic [PHASE_W-1:0]              phase_inc_i,
    output logic [LANES-1:0][PHASE_W-1:0]   lane_phase_o
);

    logic [PHASE_W-1:0] base_q;
    logic [PHASE_W-1:0] stride;

    // Distance the base phase moves in one core cycle.
    always_comb stride = PHASE_W'(LANES) * phase_inc_i;

    // Load on sync release and advance while running; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (load_i) begin
            base_q <= init_phase_i;
        end else if (run_i) begin
            base_q <= base_q + stride;
        end
    end

    // Each lane is offset from lane 0 by its index times the increment.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lane_phase_o[k] = base_q + PHASE_W'(k) * phase_inc_i;
    end

endmodule

// File: rtl/mldds_sine_lut.sv
// Phase-to-amplitude converter for one lane.
// Uses the top TBL_AW+2 phase bits: two bits select the quadrant and the rest address
// a quarter-wave table, which is mirrored and negated to give the full wave.
module mldds_sine_lut #(
    parameter int PHASE_W  = 16,
    parameter int SAMPLE_W = 16,
    parameter int TBL_AW   = 6
) (
    input  logic [PHASE_W-1:0]  phase_i,
    output logic [SAMPLE_W-1:0] sample_o
);

    localparam int TBL_N = 1 << TBL_AW;
    localparam int IDX_W = TBL_AW + 2;

    logic [SAMPLE_W-1:0] rom [TBL_N];
    logic [IDX_W-1:0]    idx;
    logic [TBL_AW-1:0]   addr;
    logic [SAMPLE_W-1:0] mag;
    logic                unused_low;

    // Constant quarter-wave table built at elaboration.
    for (genvar i = 0; i < TBL_N; i++) begin : g_rom
        localparam int AMP = mldds_pkg::quarter_amp(i, TBL_AW, SAMPLE_W);
        assign rom[i] = SAMPLE_W'(AMP);
    end

    assign unused_low = ^phase_i[PHASE_W-IDX_W-1:0];

    // Fold the phase into the first quadrant, look up, then restore the sign.
    always_comb begin
        idx      = phase_i[PHASE_W-1 -: IDX_W];
        addr     = idx[IDX_W-2] ? ~idx[TBL_AW-1:0] : idx[TBL_AW-1:0];
        mag      = rom[addr];
        sample_o = idx[IDX_W-1] ? -mag : mag;
    end

endmodule

// File: rtl/multilane_dds.sv
// Multi-lane direct digital synthesizer.
// Produces CLK_RATIO phase-coherent sine samples per core cycle for a DAC clocked
// CLK_RATIO times faster. Sync forces zero output and restarts all lanes together
// after a settling window. Assumes CLK_RATIO is a power of two from 1 to 8.
module multilane_dds #(
    parameter int CLK_RATIO = 4,
    parameter int PHASE_W   = 16,
    parameter int SAMPLE_W  = 16,
    parameter int TBL_AW    = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          sync_i,
    input  logic [PHASE_W-1:0]            phase_inc_i,
    input  logic [PHASE_W-1:0]            init_phase_i,
    output logic [CLK_RATIO*SAMPLE_W-1:0] samples_o,
    output logic                          valid_o
);

    localparam int CNT_W = $clog2(CLK_RATIO + 1);

    logic                                load_w;
    logic                                run_w;
    logic [CLK_RATIO-1:0][PHASE_W-1:0]   lane_phase;
    logic [CLK_RATIO*SAMPLE_W-1:0]       lane_amp;

    mldds_sync_ctrl #(
        .RATIO (CLK_RATIO),
        .CNT_W (CNT_W)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .sync_i (sync_i),
        .load_o (load_w),
        .run_o  (run_w)
    );

    mldds_phase_acc #(
        .LANES   (CLK_RATIO),
        .PHASE_W (PHASE_W)
    ) u_acc (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (load_w),
        .run_i        (run_w),
        .init_phase_i (init_phase_i),
        .phase_inc_i  (phase_inc_i),
        .lane_phase_o (lane_phase)
    );

    for (genvar k = 0; k < CLK_RATIO; k++) begin : g_amp
        mldds_sine_lut #(
            .PHASE_W  (PHASE_W),
            .SAMPLE_W (SAMPLE_W),
            .TBL_AW   (TBL_AW)
        ) u_lut (
            .phase_i  (lane_phase[k]),
            .sample_o (lane_amp[k*SAMPLE_W +: SAMPLE_W])
        );
    end

    // Register the samples, zeroing them whenever the generator is not running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            samples_o <= '0;
            valid_o   <= 1'b0;
        end else if (run_w) begin
            samples_o <= lane_amp;
            valid_o   <= 1'b1;
        end else begin
            samples_o <= '0;
            valid_o   <= 1'b0;
        end
    end

endmodule

// File: rtl/mldds_chk.sv
// Property checker for the multi-lane DDS.
// Counts consecutive low-sync edges on its own and relates that count to the
// block's outputs and its load strobe.
module mldds_chk #(
    parameter int RATIO = 4,
    parameter int OUT_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sync_i,
    input logic             load_w,
    input logic             valid_o,
    input logic [OUT_W-1:0] samples_o
);

    int low_run;

    // Consecutive edges with sync sampled low since reset or the last sync.
    always_ff @(posedge clk) begin
        if (!rst_n || sync_i) begin
            low_run <= 0;
        end else if (low_run < RATIO + 3) begin
            low_run <= low_run + 1;
        end
    end

    // R3
    sync_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_i |=> (!valid_o && samples_o == '0));

    // R3
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> samples_o == '0);

    // R5
    settle_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> low_run >= RATIO + 2);

    // R5
    settle_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (low_run >= RATIO + 2) |-> valid_o);

    // R4
    load_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_w |-> (low_run == 0 && !sync_i));

    // R4
    load_missing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (low_run == 0 && !sync_i) |-> load_w);

endmodule

bind multilane_dds mldds_chk #(
    .RATIO (CLK_RATIO),
    .OUT_W (CLK_RATIO*SAMPLE_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_i    (sync_i),
    .load_w    (load_w),
    .valid_o   (valid_o),
    .samples_o (samples_o)
);

// File: tb/multilane_dds_tb_top.sv
// Bench for the multi-lane DDS: a behavioural reference model compared every cycle.
module multilane_dds_tb_top;

    localparam int R  = 4;
    localparam int SW = 16;
    localparam real TWO_PI = 6.28318530717958647692;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            sync = 1'b0;
    logic [15:0]     inc = '0;
    logic [15:0]     init = '0;
    logic [R*SW-1:0] samples;
    logic            valid;

    int    vectors = 0;
    int    miscompares = 0;
    bit    done = 1'b0;
    string cur_req = "R9";

    // Reference-model state.
    int          low_run = 0;
    int unsigned acc = 0;
    bit          exp_valid = 1'b0;
    int          exp_s [R];
    string       why = "R9";

    always #2 clk = ~clk;

    multilane_dds #(.CLK_RATIO(R)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .sync_i       (sync),
        .phase_inc_i  (inc),
        .init_phase_i (init),
        .samples_o    (samples),
        .valid_o      (valid)
    );

    function automatic int ref_sine(input int unsigned ph);
        int  p;
        real v;
        p = int'((ph & 32'hFFFF) >> 8);
        v = 32767.0 * $sin(TWO_PI * (real'(p) + 0.5) / 256.0);
        if (v >= 0.0) return $rtoi(v + 0.5);
        else          return -$rtoi(-v + 0.5);
    endfunction

    // Update the model from the inputs sampled at this edge.
    task automatic model_edge();
        exp_valid = 1'b0;
        for (int k = 0; k < R; k++) exp_s[k] = 0;
        if (!rst_n) begin
            low_run = 0;
            why = "R9";
        end else if (sync) begin
            low_run = 0;
            why = "R3";
        end else begin
            low_run++;
            if (low_run == 1) acc = 32'(init);
            if (low_run >= R + 2) begin
                exp_valid = 1'b1;
                for (int k = 0; k < R; k++) exp_s[k] = ref_sine(acc + 32'(k) * 32'(inc));
                why = (low_run == R + 2) ? "R4" : cur_req;
                acc = (acc + 32'(R) * 32'(inc)) & 32'hFFFF;
            end else begin
                why = "R5";
            end
        end
    endtask

    task automatic compare();
        string tag;
        vectors++;
        if (valid !== exp_valid) begin
            miscompares++;
            $display("FAIL %s valid: got %0b expected %0b", why, valid, exp_valid);
        end
        for (int k = 0; k < R; k++) begin
            int got;
            got = int'($signed(samples[k*SW +: SW]));
            tag = (why == "R1" && k > 0) ? "R2" : why;
            vectors++;
            if (got != exp_s[k]) begin
                miscompares++;
                $display("FAIL %s lane %0d: got %0d expected %0d", tag, k, got, exp_s[k]);
            end
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            model_edge();
            @(negedge clk);
            compare();
        end
    endtask

    initial begin
        // R9: reset holds outputs at zero, then acts as a sync release.
        @(negedge clk);
        inc = 16'h0123;
        init = 16'h0000;
        step(3);
        rst_n = 1'b1;
        cur_req = "R1";
        step(20);

        // R3, R5, R4 and R2: long sync pulse, new phase and frequency.
        sync = 1'b1;
        init = 16'h4000;
        inc = 16'h0800;
        step(5);
        sync = 1'b0;
        cur_req = "R2";
        step(15);

        // R7: large increment forces accumulator wrap.
        cur_req = "R7";
        inc = 16'h3FFF;
        step(20);

        // R8: increment changes every cycle without a restart.
        cur_req = "R8";
        for (int i = 0; i < 10; i++) begin
            inc = 16'(16'h0100 + i * 16'h0731);
            step(1);
        end

        // R6: one-cycle pulse.
        cur_req = "R6";
        init = 16'h9ABC;
        inc = 16'h0555;
        sync = 1'b1;
        step(1);
        sync = 1'b0;
        step(12);

        // R6: sync re-asserted two cycles into the settling window.
        sync = 1'b1;
        step(1);
        sync = 1'b0;
        step(2);
        sync = 1'b1;
        init = 16'h1357;
        step(1);
        sync = 1'b0;
        step(12);

        // R1: zero increment yields a constant vector.
        cur_req = "R1";
        inc = 16'h0000;
        init = 16'hC000;
        sync = 1'b1;
        step(2);
        sync = 1'b0;
        step(10);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule